// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor

This block supplies a guess for every fetch address: whether the instruction there is a taken branch, and where fetch should go next. Two direct-mapped arrays, one of direction counters and one of branch targets, are read through the same index taken from the fetch PC. The lookup is combinational, so the guess is available in the same cycle as the fetch PC. When the next fetch address is not a taken guess, it is the fetch PC plus four.

Resolved branches come back from the execute stage on a separate update port. Every valid update trains the direction entry with the real outcome. The target entry is rewritten only when execute reports that the earlier guess was wrong and the branch was really taken. Entries carry no tag, so unrelated PCs that share index bits share an entry, and any wrong guess that results is repaired by the normal update path. Redirecting or flushing the pipeline is left to the caller.

Both ports follow valid-only stream rules. The block accepts a lookup and an update in every cycle and never applies back-pressure, so no ready signal exists. An update that lands in a cycle is not seen by a lookup in that same cycle; it is seen from the next cycle on.

Top module: `bpred_top`

## Requirements
- R1: The entry index is PC bits [2 +: log2(ENTRIES)]; PC bits 1:0 and all bits above the index have no effect on which entry a lookup or update uses (PCs sharing the index bits share an entry, with no tag check).
- R2: After reset every direction entry predicts not-taken (2-bit counter value 01, 1-bit value 0) and every target entry holds zero.
- R3: With TWO_BIT_CTR=1 each entry is a 2-bit counter: a taken update adds one, a not-taken update subtracts one, saturating at 11 and 00; values 10 and 11 predict taken, 01 and 00 predict not-taken.
- R4: With TWO_BIT_CTR=0 each entry is one bit holding the last update's outcome (1 = taken), and the prediction equals that bit.
- R5: When pr_taken is 0, pr_next_pc equals fe_pc + 4 modulo 2^PC_W.
- R6: A target entry is written with ex_target only when ex_valid, ex_mispredict and ex_taken are all 1; any other update leaves the stored target unchanged.
- R7: When pr_taken is 1, pr_next_pc equals the target stored in the indexed entry.
- R8: An update takes effect at the clock edge where ex_valid is sampled: a lookup of the same entry in that cycle sees the old state, and one in the next cycle sees the new state.
- R9: When ex_valid is 0, no direction or target entry changes; pr_valid always equals fe_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| fe_valid | input | 1 | Fetch lookup request valid |
| fe_pc | input | PC_W | Fetch PC to look up |
| pr_valid | output | 1 | Prediction valid, follows fe_valid |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_next_pc | output | PC_W | Predicted next fetch address |
| ex_valid | input | 1 | Resolved-branch update valid |
| ex_pc | input | PC_W | PC of the resolved branch |
| ex_taken | input | 1 | Real outcome, 1 = taken |
| ex_target | input | PC_W | Real target of the branch |
| ex_mispredict | input | 1 | Execute found the earlier guess wrong |

## Verification
The bench builds two copies side by side from the same stimulus: one with the default 64 entries and 2-bit counters, and one with 16 entries and the 1-bit last-outcome mode. The small copy puts index aliasing within easy reach of a short PC pool, and it is the only way the 1-bit mode gets exercised; the large copy reaches counter saturation at both ends and the PC+4 wrap at the top of the address space.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_t;

  localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

  // saturating step of a 2-bit direction counter
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LSB    = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[LSB-1:0], pc[PC_W-1:LSB+IDX_W]};
  assign idx = pc[LSB +: IDX_W];
endmodule

// File: rtl/bp_dir_array.sv
module bp_dir_array
  import bp_pkg::*;
#(
  parameter int ENTRIES     = 64,
  parameter bit TWO_BIT_CTR = 1'b1,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  generate
    if (TWO_BIT_CTR) begin : g_ctr2
      logic [ENTRIES-1:0][1:0] ctr_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
        end else if (wr_en) begin
          ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
      end

      assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);

      // R3
      ctr_taken_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken |=> ctr_q[$past(wr_idx)] != CTR_STRONG_NT);
      // R3
      ctr_nt_nonmax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken |=> ctr_q[$past(wr_idx)] != CTR_STRONG_T);
      // R9
      ctr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctr_q));

      for (genvar e = 0; e < ENTRIES; e++) begin : g_step
        // R3
        ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
          ({1'b0, ctr_q[e]} == {1'b0, $past(ctr_q[e])}) ||
          ({1'b0, ctr_q[e]} == {1'b0, $past(ctr_q[e])} + 3'd1) ||
          ({1'b0, ctr_q[e]} + 3'd1 == {1'b0, $past(ctr_q[e])}));
      end
    end else begin : g_ctr1
      logic [ENTRIES-1:0] last_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     last_q <= '0;
        else if (wr_en) last_q[wr_idx] <= wr_taken;
      end

      assign rd_taken = last_q[rd_idx];

      // R4
      last_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> last_q[$past(wr_idx)] == $past(wr_taken));
      // R9
      last_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(last_q));
    end
  endgenerate

endmodule

// File: rtl/bp_target_array.sv
module bp_target_array #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tgt
);
  logic [ENTRIES-1:0][PC_W-1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tgt_q <= '0;
    else if (wr_en) tgt_q[wr_idx] <= wr_tgt;
  end

  assign rd_tgt = tgt_q[rd_idx];

  // R6
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tgt_q));
  // R6
  tgt_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tgt_q[$past(wr_idx)] == $past(wr_tgt));

endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
  parameter int ENTRIES     = 64,
  parameter int PC_W        = 32,
  parameter bit TWO_BIT_CTR = 1'b1,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fe_valid,
  input  logic [PC_W-1:0] fe_pc,
  output logic            pr_valid,
  output logic            pr_taken,
  output logic [PC_W-1:0] pr_next_pc,
  input  logic            ex_valid,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  input  logic            ex_mispredict
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [PC_W-1:0]  stored_tgt;
  logic             tgt_wr_en;

  bp_index #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_rd_index (.pc(fe_pc), .idx(rd_idx));
  bp_index #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_wr_index (.pc(ex_pc), .idx(wr_idx));

  bp_dir_array #(.ENTRIES(ENTRIES), .TWO_BIT_CTR(TWO_BIT_CTR)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_taken(pr_taken),
    .wr_en(ex_valid), .wr_idx(wr_idx), .wr_taken(ex_taken)
  );

  assign tgt_wr_en = ex_valid && ex_mispredict && ex_taken;

  bp_target_array #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_tgt(stored_tgt),
    .wr_en(tgt_wr_en), .wr_idx(wr_idx), .wr_tgt(ex_target)
  );

  assign pr_valid   = fe_valid;
  assign pr_next_pc = pr_taken ? stored_tgt : fe_pc + INSN_BYTES;

  // R6
  no_tgt_write_without_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mispredict |-> !tgt_wr_en);
  // R5
  fallthrough_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid && !pr_taken |-> (pr_next_pc - fe_pc) == INSN_BYTES);

endmodule

// File: tb/sim_bpred_top.sv
`timescale 1ns/1ps
module sim_bpred_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe_valid = 1'b0;
  logic [31:0] fe_pc = '0;
  logic        ex_valid = 1'b0, ex_taken = 1'b0, ex_mispredict = 1'b0;
  logic [31:0] ex_pc = '0, ex_target = '0;
  logic        pv0, pt0, pv1, pt1;
  logic [31:0] nx0, nx1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bpred_top u0 (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_pc(fe_pc),
    .pr_valid(pv0), .pr_taken(pt0), .pr_next_pc(nx0),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .ex_target(ex_target), .ex_mispredict(ex_mispredict));

  bpred_top #(.ENTRIES(16), .PC_W(32), .TWO_BIT_CTR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_pc(fe_pc),
    .pr_valid(pv1), .pr_taken(pt1), .pr_next_pc(nx1),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .ex_target(ex_target), .ex_mispredict(ex_mispredict));

  // bench model
  int          m_ctr [64];
  logic [31:0] m_tgt0 [64];
  logic        m_last [16];
  logic [31:0] m_tgt1 [16];

  function automatic int ix0(logic [31:0] pc); return int'(pc[7:2]); endfunction
  function automatic int ix1(logic [31:0] pc); return int'(pc[5:2]); endfunction

  function automatic logic exp_t0(logic [31:0] pc); return m_ctr[ix0(pc)] >= 2; endfunction
  function automatic logic [31:0] exp_n0(logic [31:0] pc);
    return exp_t0(pc) ? m_tgt0[ix0(pc)] : pc + 32'd4;
  endfunction
  function automatic logic [31:0] exp_n1(logic [31:0] pc);
    return m_last[ix1(pc)] ? m_tgt1[ix1(pc)] : pc + 32'd4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_ctr[i] = 1; m_tgt0[i] = '0; end
    for (int i = 0; i < 16; i++) begin m_last[i] = 1'b0; m_tgt1[i] = '0; end
  endtask

  task automatic model_update();
    if (ex_valid) begin
      if (ex_taken && m_ctr[ix0(ex_pc)] < 3) m_ctr[ix0(ex_pc)]++;
      if (!ex_taken && m_ctr[ix0(ex_pc)] > 0) m_ctr[ix0(ex_pc)]--;
      m_last[ix1(ex_pc)] = ex_taken;
      if (ex_mispredict && ex_taken) begin
        m_tgt0[ix0(ex_pc)] = ex_target;
        m_tgt1[ix1(ex_pc)] = ex_target;
      end
    end
  endtask

  // drive at negedge, check combinational lookup, then let the edge land
  task automatic cyc(input string tag, input logic fv, input logic [31:0] fpc,
                     input logic ev, input logic [31:0] epc, input logic et,
                     input logic [31:0] etgt, input logic emis);
    fe_valid = fv; fe_pc = fpc;
    ex_valid = ev; ex_pc = epc; ex_taken = et; ex_target = etgt; ex_mispredict = emis;
    #1;
    chk({tag, " R9 valid"}, {31'd0, pv0}, {31'd0, fv});
    chk({tag, " dir"},  {31'd0, pt0}, {31'd0, exp_t0(fpc)});
    chk({tag, " next"}, nx0, exp_n0(fpc));
    chk({"R4 ", tag, " dir1"},  {31'd0, pt1}, {31'd0, m_last[ix1(fpc)]});
    chk({"R4 ", tag, " next1"}, nx1, exp_n1(fpc));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic look(input string tag, input logic [31:0] fpc);
    cyc(tag, 1'b1, fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state, R5 fall-through including wrap
    look("R2 R5 reset", 32'h0000_0100);
    look("R2 R5 wrap", 32'hFFFF_FFFC);
    #1; chk("R5 wrap value", nx0, 32'h0);
    // R6: taken without mispredict leaves target zero, R2 target reset
    cyc("R6", 1'b0, 32'h0, 1'b1, 32'h100, 1'b1, 32'h0000_ABC0, 1'b0);
    look("R6 R2 tgt zero", 32'h100);
    #1; chk("R6 tgt kept", nx0, 32'h0);
    // R7 mispredict writes target
    cyc("R7 train", 1'b0, 32'h0, 1'b1, 32'h100, 1'b1, 32'h0000_2000, 1'b1);
    look("R7", 32'h100);
    #1; chk("R7 target", nx0, 32'h2000);
    // R1 aliasing: upper and low bits ignored
    look("R1 alias hi", 32'h0000_0200);
    look("R1 alias lo", 32'h0000_0103);
    look("R1 alias far", 32'h8000_4100);
    // R8 same-cycle update invisible, visible next cycle
    cyc("R8 same", 1'b1, 32'h40, 1'b1, 32'h40, 1'b1, 32'h0000_0500, 1'b1);
    look("R8 next", 32'h40);
    #1; chk("R8 next taken", {31'd0, pt0}, 32'd1);
    // R3 saturation up and down
    for (int k = 0; k < 3; k++) cyc("R3 up", 1'b0, 0, 1'b1, 32'h40, 1'b1, 32'h500, 1'b0);
    look("R3 sat hi", 32'h40);
    cyc("R3 dn", 1'b0, 0, 1'b1, 32'h40, 1'b0, 32'h0, 1'b0);
    look("R3 weak t", 32'h40);
    #1; chk("R3 10 taken", {31'd0, pt0}, 32'd1);
    for (int k = 0; k < 3; k++) cyc("R3 dn", 1'b0, 0, 1'b1, 32'h40, 1'b0, 32'h0, 1'b0);
    look("R3 sat lo", 32'h40);
    cyc("R3 up1", 1'b0, 0, 1'b1, 32'h40, 1'b1, 32'h0, 1'b0);
    look("R3 01 not taken", 32'h40);
    #1; chk("R3 01 nt", {31'd0, pt0}, 32'd0);
    // R9 idle update fields ignored
    cyc("R9 idle", 1'b0, 32'h0, 1'b0, 32'h40, 1'b1, 32'h999, 1'b1);
    look("R9 after idle", 32'h40);
    look("R9 tgt idle", 32'h100);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] fpc, epc;
      fpc = {22'd0, 4'($urandom % 16), 4'($urandom % 16), 2'($urandom % 4)};
      epc = {22'd0, 4'($urandom % 16), 4'($urandom % 16), 2'($urandom % 4)};
      if ($urandom % 16 == 0) fpc = fpc | 32'hFFFF_0000;
      cyc("R1/R3/R5/R7/R8 rand", 1'($urandom % 4 != 0), fpc,
          1'($urandom % 10 < 7), epc, 1'($urandom % 2),
          $urandom & 32'hFFFF_FFFC, 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule